// File: doc/BRIEF.md
# PMP Configuration and Security Register File

This block holds the configuration state for physical memory protection: one configuration byte and one address register per protection entry, plus a machine security register that carries three control flags. These are a lockdown flag, a whitelist flag and a lock-bypass flag. Software reaches this state through a plain CSR port made of an address, write data, a write enable and a combinational read-data return. The block decides, byte by byte and register by register, whether each write may land. It also drives the stored state to a separate permission checker.

The three security flags are sticky in different directions. The lockdown and whitelist flags can only be raised. The lock-bypass flag can always be dropped, but it can be raised only while no entry is locked. Locked entries refuse changes unless the bypass is active. While lockdown is on and the bypass is off, configuration writes that would create a locked executable or shared-code rule are refused. The active-low reset is the PMP reset. It returns every register to safe defaults, locked entries included.

Top module: `pmpreg_file`

## Requirements
- R1: After reset every configuration byte reads 0x00, every address register reads 0, and the security register reads 0.
- R2: CSR map. Configuration CSR k sits at CFG_BASE+k and carries entry 4k+j in bits [8j+7:8j]. Address register i sits at ADDR_BASE+i. The security register sits at SEC_ADDR with the lockdown flag at bit 0, the whitelist flag at bit 1 and the bypass flag at bit 2. Bits 31:3 of the security register read 0 and ignore writes. Any other address reads 0.
- R3: The layout of a configuration byte is lock at bit 7, mode at bits 4:3 (00 off, 01 top-of-range), execute at bit 2, write at bit 1 and read at bit 0. Bits 6:5 always read 0. Each byte of a configuration CSR write is accepted or refused on its own.
- R4: An entry whose lock bit is 1 ignores writes to its configuration byte and to its address register, unless the bypass flag is 1.
- R5: If entry i+1 is locked and in top-of-range mode, writes to address register i are ignored, unless the bypass flag is 1.
- R6: A write of 1 sets the lockdown flag or the whitelist flag. A write of 0 never clears either flag.
- R7: A write of 0 always clears the bypass flag. A write of 1 sets it only if it is already 1 or no entry is locked.
- R8: While lockdown=1 and bypass=0, a configuration byte write is refused if it has lock=1 and either write=1 with read=0, or execute=1 without both read and write. The old byte stays in place.
- R9: Asserting reset mid-run clears all entries (locked ones included) and all three flags.
- R10: The configuration, address and flag outputs always equal the stored values that CSR reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous PMP reset |
| csr_addr | input | CSR_AW | CSR address for reads and writes |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| pmp_cfg_o | output | 8*NUM_ENTRIES | Configuration bytes; entry i at [8i+7:8i] |
| pmp_addr_o | output | ADDR_W*NUM_ENTRIES | Address registers; entry i at [ADDR_W*i +: ADDR_W] |
| sec_mml_o | output | 1 | Lockdown flag |
| sec_mmwp_o | output | 1 | Whitelist flag |
| sec_rlb_o | output | 1 | Lock-bypass flag |

## Verification
A write that is presented with csr_we high is decided on the next rising edge, so its effect appears one cycle later. Read data follows csr_addr combinationally in the same cycle, and reset clears all state at once without waiting for a clock. The bench drives each write on a falling edge and holds it for one full cycle. It then moves the address and samples csr_rdata one time unit after the following falling edge. All accept and refuse decisions are therefore observed after exactly one register stage. Reset effects are sampled while reset is still low.

// File: rtl/pmpreg_pkg.sv
package pmpreg_pkg;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] rsvd;
      amode_e     mode;
      logic       x;
      logic       w;
      logic       r;
   } cfg_byte_t;

   localparam int SEC_MML_BIT  = 0;
   localparam int SEC_MMWP_BIT = 1;
   localparam int SEC_RLB_BIT  = 2;

   // Locked byte that grants machine-mode execute or forms a shared code region
   function automatic logic lockdown_forbidden(input cfg_byte_t b);
      return b.lock & ((b.w & ~b.r) | (b.x & ~(b.r & b.w)));
   endfunction

endpackage

// File: rtl/pmpreg_cfg_lane.sv
module pmpreg_cfg_lane
   import pmpreg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  cfg_byte_t wr_byte,
   input  logic      bypass,
   input  logic      lockdown,
   output cfg_byte_t cur
);

   logic accept;

   always_comb begin
      accept = wr_en & (~cur.lock | bypass)
               & ~(lockdown & ~bypass & lockdown_forbidden(wr_byte));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (accept) begin
         cur <= wr_byte;
      end
   end

endmodule

// File: rtl/pmpreg_addr_slot.sv
module pmpreg_addr_slot #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              blocked,
   output logic [ADDR_W-1:0] value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr_en && !blocked) begin
         value <= wr_data;
      end
   end

endmodule

// File: rtl/pmpreg_sec.sv
module pmpreg_sec
   import pmpreg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_bits,
   input  logic       any_locked,
   output logic       mml,
   output logic       mmwp,
   output logic       rlb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mml  <= 1'b0;
         mmwp <= 1'b0;
         rlb  <= 1'b0;
      end else if (wr_en) begin
         mml  <= mml  | wr_bits[SEC_MML_BIT];
         mmwp <= mmwp | wr_bits[SEC_MMWP_BIT];
         rlb  <= wr_bits[SEC_RLB_BIT] & (rlb | ~any_locked);
      end
   end

endmodule

// File: rtl/pmpreg_file.sv
module pmpreg_file
   import pmpreg_pkg::*;
#(
   parameter int          NUM_ENTRIES = 16,
   parameter int          XLEN        = 32,
   parameter int          ADDR_W      = 32,
   parameter int          CSR_AW      = 12,
   parameter int unsigned CFG_BASE    = 'h3A0,
   parameter int unsigned ADDR_BASE   = 'h3B0,
   parameter int unsigned SEC_ADDR    = 'h747
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CSR_AW-1:0]             csr_addr,
   input  logic                          csr_we,
   input  logic [XLEN-1:0]               csr_wdata,
   output logic [XLEN-1:0]               csr_rdata,
   output logic [8*NUM_ENTRIES-1:0]      pmp_cfg_o,
   output logic [ADDR_W*NUM_ENTRIES-1:0] pmp_addr_o,
   output logic                          sec_mml_o,
   output logic                          sec_mmwp_o,
   output logic                          sec_rlb_o
);

   localparam int CFG_PER_CSR = XLEN / 8;
   localparam int CFG_CSRS    = NUM_ENTRIES / CFG_PER_CSR;

   if (XLEN % 32 != 0) begin : g_bad_xlen
      $error("pmpreg_file: XLEN must be a multiple of 32");
   end
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64 || (NUM_ENTRIES % CFG_PER_CSR) != 0) begin : g_bad_n
      $error("pmpreg_file: NUM_ENTRIES must be 1..64 and fill whole configuration CSRs");
   end
   if (ADDR_W > XLEN || ADDR_W < 1) begin : g_bad_aw
      $error("pmpreg_file: ADDR_W must be 1..XLEN");
   end
   if (CFG_CSRS < 1) begin : g_bad_csrs
      $error("pmpreg_file: no configuration CSR");
   end

   cfg_byte_t         cfg_q   [NUM_ENTRIES];
   logic [ADDR_W-1:0] addr_q  [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] lock_vec;
   logic              mml, mmwp, rlb;
   logic              sec_hit;

   assign sec_hit = (csr_addr == CSR_AW'(SEC_ADDR));

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      localparam int CSR_IDX = i / CFG_PER_CSR;
      localparam int LANE    = i % CFG_PER_CSR;

      logic      cfg_hit, addr_hit, addr_blk;
      cfg_byte_t wr_byte;

      assign cfg_hit  = (csr_addr == CSR_AW'(CFG_BASE + CSR_IDX));
      assign addr_hit = (csr_addr == CSR_AW'(ADDR_BASE + i));

      always_comb begin
         wr_byte      = csr_wdata[8*LANE +: 8];
         wr_byte.rsvd = 2'b00;
      end

      pmpreg_cfg_lane u_cfg (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (csr_we & cfg_hit),
         .wr_byte  (wr_byte),
         .bypass   (rlb),
         .lockdown (mml),
         .cur      (cfg_q[i])
      );

      if (i < NUM_ENTRIES - 1) begin : g_tor_guard
         assign addr_blk = ~rlb & (cfg_q[i].lock |
                           (cfg_q[i+1].lock & (cfg_q[i+1].mode == AM_TOR)));
      end else begin : g_last
         assign addr_blk = ~rlb & cfg_q[i].lock;
      end

      pmpreg_addr_slot #(.ADDR_W(ADDR_W)) u_addr (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (csr_we & addr_hit),
         .wr_data (csr_wdata[ADDR_W-1:0]),
         .blocked (addr_blk),
         .value   (addr_q[i])
      );

      assign lock_vec[i]                      = cfg_q[i].lock;
      assign pmp_cfg_o[8*i +: 8]              = cfg_q[i];
      assign pmp_addr_o[ADDR_W*i +: ADDR_W]   = addr_q[i];
   end

   pmpreg_sec u_sec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (csr_we & sec_hit),
      .wr_bits    (csr_wdata[2:0]),
      .any_locked (|lock_vec),
      .mml        (mml),
      .mmwp       (mmwp),
      .rlb        (rlb)
   );

   always_comb begin
      csr_rdata = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (csr_addr == CSR_AW'(CFG_BASE + i / CFG_PER_CSR)) begin
            csr_rdata[8*(i % CFG_PER_CSR) +: 8] = cfg_q[i];
         end
         if (csr_addr == CSR_AW'(ADDR_BASE + i)) begin
            csr_rdata = XLEN'(addr_q[i]);
         end
      end
      if (sec_hit) begin
         csr_rdata = XLEN'({rlb, mmwp, mml});
      end
   end

   assign sec_mml_o  = mml;
   assign sec_mmwp_o = mmwp;
   assign sec_rlb_o  = rlb;

endmodule

// File: rtl/pmpreg_file_chk.sv
module pmpreg_file_chk
   import pmpreg_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int ADDR_W      = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [8*NUM_ENTRIES-1:0]      pmp_cfg_o,
   input logic [ADDR_W*NUM_ENTRIES-1:0] pmp_addr_o,
   input logic                          sec_mml_o,
   input logic                          sec_mmwp_o,
   input logic                          sec_rlb_o
);

   logic any_lock;
   always_comb begin
      any_lock = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) any_lock |= pmp_cfg_o[8*i+7];
   end

   AST_MML_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_mml_o |=> sec_mml_o); // R6
   AST_MMWP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_mmwp_o |=> sec_mmwp_o); // R6
   AST_RLB_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_rlb_o && any_lock) |=> !sec_rlb_o); // R7

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
      AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (pmp_cfg_o[8*i+7] && !sec_rlb_o) |=> $stable(pmp_cfg_o[8*i +: 8])); // R4
      AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (pmp_cfg_o[8*i+7] && !sec_rlb_o) |=> $stable(pmp_addr_o[ADDR_W*i +: ADDR_W])); // R4
      AST_LOCKDOWN_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
         (sec_mml_o && !sec_rlb_o && !pmp_cfg_o[8*i+7])
         |=> !lockdown_forbidden(cfg_byte_t'(pmp_cfg_o[8*i +: 8]))); // R8
      if (i < NUM_ENTRIES - 1) begin : g_tor
         AST_TOR_BELOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pmp_cfg_o[8*(i+1)+7] && pmp_cfg_o[8*(i+1)+3 +: 2] == 2'b01 && !sec_rlb_o)
            |=> $stable(pmp_addr_o[ADDR_W*i +: ADDR_W])); // R5
      end
   end

endmodule

bind pmpreg_file pmpreg_file_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pmp_cfg_o  (pmp_cfg_o),
   .pmp_addr_o (pmp_addr_o),
   .sec_mml_o  (sec_mml_o),
   .sec_mmwp_o (sec_mmwp_o),
   .sec_rlb_o  (sec_rlb_o)
);

// File: tb/pmpreg_file_bench.sv
`timescale 1ns/1ps
module pmpreg_file_bench;

   localparam int N  = 16;
   localparam int AW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       csr_addr = '0;
   logic              csr_we = 1'b0;
   logic [31:0]       csr_wdata = '0;
   logic [31:0]       csr_rdata;
   logic [8*N-1:0]    pmp_cfg_o;
   logic [AW*N-1:0]   pmp_addr_o;
   logic              sec_mml_o, sec_mmwp_o, sec_rlb_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pmpreg_file u_pmpreg_file (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .pmp_cfg_o(pmp_cfg_o),
      .pmp_addr_o(pmp_addr_o), .sec_mml_o(sec_mml_o), .sec_mmwp_o(sec_mmwp_o),
      .sec_rlb_o(sec_rlb_o)
   );

   typedef struct packed {
      logic        we;
      logic [11:0] waddr;
      logic [31:0] wdata;
      logic [11:0] raddr;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 12'h3B0, 32'h0000_1000, 12'h3B0, 32'h0000_1000, 4'd2},  // R2 address write
      '{1'b1, 12'h3A0, 32'h0000_0F0B, 12'h3A0, 32'h0000_0F0B, 4'd3},  // R3 packing
      '{1'b1, 12'h3A0, 32'h0000_006B, 12'h3A0, 32'h0000_000B, 4'd3},  // R3 reserved bits
      '{1'b1, 12'h3B1, 32'h0000_2000, 12'h3B1, 32'h0000_2000, 4'd2},  // R2
      '{1'b1, 12'h3A0, 32'h0000_8B0B, 12'h3A0, 32'h0000_8B0B, 4'd3},  // R3 lock entry 1 TOR
      '{1'b1, 12'h3A0, 32'h0000_0003, 12'h3A0, 32'h0000_8B03, 4'd4},  // R4 per-byte lock
      '{1'b1, 12'h3B1, 32'h0000_3000, 12'h3B1, 32'h0000_2000, 4'd4},  // R4 locked address
      '{1'b1, 12'h3B0, 32'h0000_5555, 12'h3B0, 32'h0000_1000, 4'd5},  // R5 TOR below
      '{1'b1, 12'h3B2, 32'h0000_7777, 12'h3B2, 32'h0000_7777, 4'd5},  // R5 unaffected
      '{1'b1, 12'h747, 32'h0000_0004, 12'h747, 32'h0000_0000, 4'd7},  // R7 set refused
      '{1'b1, 12'h747, 32'h0000_0001, 12'h747, 32'h0000_0001, 4'd6},  // R6 set lockdown
      '{1'b1, 12'h747, 32'h0000_0000, 12'h747, 32'h0000_0001, 4'd6},  // R6 sticky
      '{1'b1, 12'h747, 32'h0000_0002, 12'h747, 32'h0000_0003, 4'd6},  // R6 whitelist
      '{1'b1, 12'h747, 32'hFFFF_FFF8, 12'h747, 32'h0000_0003, 4'd2},  // R2 upper bits
      '{1'b1, 12'h3A1, 32'h999F_9A9C, 12'h3A1, 32'h999F_0000, 4'd8},  // R8 lockdown filter
      '{1'b1, 12'h3A1, 32'h0000_1F9D, 12'h3A1, 32'h999F_1F00, 4'd8},  // R8 mixed
      '{1'b0, 12'h000, 32'h0000_0000, 12'h123, 32'h0000_0000, 4'd2}   // R2 unmapped
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr  = a;
      csr_wdata = d;
      csr_we    = 1'b1;
      @(negedge clk);
      csr_we    = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      csr_addr = a;
      #1;
      check(req, 64'(csr_rdata), 64'(exp));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      check("R1 cfg", 64'(pmp_cfg_o[63:0]), 64'h0);
      check("R1 addr", 64'(pmp_addr_o[63:0]), 64'h0);
      check("R1 flags", 64'({sec_rlb_o, sec_mmwp_o, sec_mml_o}), 64'h0);
      rd(12'h747, 32'h0, "R1 sec read");

      for (int v = 0; v < NV; v++) begin
         if (VECS[v].we) wr(VECS[v].waddr, VECS[v].wdata);
         else @(negedge clk);
         rd(VECS[v].raddr, VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
      end

      // R10 outputs track stored state
      check("R10 cfg1", 64'(pmp_cfg_o[15:8]), 64'h8B);
      check("R10 addr1", 64'(pmp_addr_o[63:32]), 64'h2000);
      check("R10 flags", 64'({sec_rlb_o, sec_mmwp_o, sec_mml_o}), 64'h3);

      // R9 mid-run reset clears locked state
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 cfg", 64'(pmp_cfg_o[63:0]), 64'h0);
      check("R9 addr", 64'(pmp_addr_o[63:0]), 64'h0);
      check("R9 flags", 64'({sec_rlb_o, sec_mmwp_o, sec_mml_o}), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd(12'h3A0, 32'h0, "R1 cfg read after reset");

      // Bypass flag scenarios
      wr(12'h747, 32'h4);         rd(12'h747, 32'h4,   "R7 set with no lock");
      wr(12'h3A0, 32'h89);        rd(12'h3A0, 32'h89,  "R3 lock entry0");
      wr(12'h3A0, 32'h00);        rd(12'h3A0, 32'h00,  "R4 bypass cfg");
      wr(12'h3A0, 32'h89);
      wr(12'h3B0, 32'hABC);       rd(12'h3B0, 32'hABC, "R4 bypass addr");
      wr(12'h747, 32'h5);         rd(12'h747, 32'h5,   "R6 lockdown with bypass");
      wr(12'h3A0, 32'h9C);        rd(12'h3A0, 32'h9C,  "R8 bypass allows");
      wr(12'h747, 32'h1);         rd(12'h747, 32'h1,   "R7 clear");
      wr(12'h747, 32'h5);         rd(12'h747, 32'h1,   "R7 no re-set");
      wr(12'h3A0, 32'h00);        rd(12'h3A0, 32'h9C,  "R4 locked cfg");
      wr(12'h3B0, 32'h1);         rd(12'h3B0, 32'hABC, "R4 locked addr");
      check("R10 cfg0 port", 64'(pmp_cfg_o[7:0]), 64'h9C);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule